// File: doc/BRIEF.md
# Wide-to-Narrow Bus Bridge with Byte-Lane Steering

This block joins a 16-bit word-addressed bus to an 8-bit byte-addressed bus. It is used in both directions. When the wide-side host owns the narrow bus, the host's word address and its two active-low byte strobes become a byte address on the narrow side, and the bridge picks which byte lane of the host data carries the byte. When the narrow-side master owns the wide bus, the master's byte address picks the lane, and the bridge raises only the matching wide write strobe.

Two direction inputs say which way data flows. Narrow-to-wide covers host reads and master writes. Wide-to-narrow covers host writes and master reads. The low address bit on the narrow side is taken from the upper host strobe alone. As a result, a full-word host write lands only in the even byte. Whenever the wide bus is driven from the narrow bus, the byte appears on both halves of the wide bus.

An ownership input chooses the path. Arbitration itself happens outside the block. Every output is registered, and tri-state drive is modelled as output-enable flags. A data output that is not driven holds zero.

Top module: `lane_bridge`

## Requirements
- R1: On a host cycle (ownership = 1, a host strobe low, one direction asserted), narrow address bits [7:1] equal host address bits [7:1].
- R2: Narrow address bit 0 equals the upper strobe level sampled at the first clock edge where either strobe is low. It holds that value on later edges until both strobes are seen high, even if the upper strobe changes in between.
- R3: A host write with only the upper strobe low puts host data [15:8] on the narrow bus at an even address. A write with only the lower strobe low puts data [7:0] there at an odd address.
- R4: A host write with both strobes low gives a single narrow write at the even address carrying data [15:8]. No write is issued to the odd address, and data [7:0] is dropped.
- R5: A host read (narrow-to-wide) drives the wide read bus with the narrow byte in both bits [15:8] and bits [7:0], whichever strobes are low.
- R6: A master read (ownership = 0, master select = 1, wide-to-narrow) returns wide data [7:0] when master address bit 0 is 1, and data [15:8] when it is 0. Wide address bits [7:1] equal master address bits [7:1].
- R7: A master write (narrow-to-wide) drives the master byte on both wide halves. Only the upper write strobe goes low when address bit 0 is 0, and only the lower one when it is 1.
- R8: With no direction asserted, or no cycle presented by the side that owns the bridge, the following all hold: every output enable is low, all strobes are high, every data output and both addresses are zero, and a cycle presented by the non-owning side has no effect.
- R9: With both directions asserted, the error flag is 1 and every output is at its idle value as in R8.
- R10: Outputs change only at the first clock edge after their inputs change, which is one cycle of latency.
- R11: Synchronous active-high reset puts every output at its idle value and the error flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| host_owner | input | 1 | 1: wide host drives the narrow bus; 0: narrow master drives the wide bus |
| dir_n2w | input | 1 | Narrow-to-wide transfer enable |
| dir_w2n | input | 1 | Wide-to-narrow transfer enable |
| h_addr | input | 7 | Host word address bits [7:1] |
| h_wdata | input | 16 | Host write data |
| h_uds_n | input | 1 | Host upper byte strobe, active low |
| h_lds_n | input | 1 | Host lower byte strobe, active low |
| h_rdata | output | 16 | Read data returned to the host |
| h_rdata_oe | output | 1 | Host read data drive enable |
| p_addr | output | 8 | Narrow bus byte address |
| p_wdata | output | 8 | Narrow bus write data |
| p_wdata_oe | output | 1 | Narrow write data drive enable |
| p_rdata | input | 8 | Narrow bus read data |
| p_rd_n | output | 1 | Narrow read strobe, active low |
| p_wr_n | output | 1 | Narrow write strobe, active low |
| m_sel | input | 1 | Narrow master cycle request |
| m_addr | input | 8 | Narrow master byte address |
| m_wdata | input | 8 | Narrow master write data |
| m_rdata | output | 8 | Read data returned to the narrow master |
| m_rdata_oe | output | 1 | Master read data drive enable |
| w_addr | output | 7 | Wide bus word address bits [7:1] |
| w_wdata | output | 16 | Wide bus write data |
| w_wdata_oe | output | 1 | Wide write data drive enable |
| w_rdata | input | 16 | Wide bus read data |
| w_rd_n | output | 1 | Wide read strobe, active low |
| w_uwr_n | output | 1 | Wide upper-lane write strobe, active low |
| w_lwr_n | output | 1 | Wide lower-lane write strobe, active low |
| dir_err | output | 1 | Both directions asserted at once |

## Verification
The hardest case to reach from the ports is the held address bit. It only shows when the upper strobe changes level while a host cycle is already open and neither strobe has returned high. The bench opens a host write with only the lower strobe low. It then drops the upper strobe on the next cycle without an idle cycle in between, and checks that the odd address and the lower lane remain. After releasing both strobes it repeats the cycle and expects the even address. Each table vector is preceded by an idle cycle, so every vector starts from a released strobe state.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;

  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_N2W   = 2'd1,
    DIR_W2N   = 2'd2,
    DIR_CLASH = 2'd3
  } dir_e;

  function automatic dir_e dir_decode(input logic n2w, input logic w2n);
    case ({w2n, n2w})
      2'b01:   return DIR_N2W;
      2'b10:   return DIR_W2N;
      2'b11:   return DIR_CLASH;
      default: return DIR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lane_a0_track.sv
module lane_a0_track (
  input  logic clk,
  input  logic rst,
  input  logic uds_n,
  input  logic lds_n,
  output logic a0_eff
);

  logic held_q;
  logic a0_q;
  logic any_strobe;

  assign any_strobe = !(uds_n && lds_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      a0_q   <= 1'b1;
    end else if (!any_strobe) begin
      held_q <= 1'b0;
    end else if (!held_q) begin
      held_q <= 1'b1;
      a0_q   <= uds_n;
    end
  end

  // first strobe edge takes the live level, later edges reuse the capture
  assign a0_eff = held_q ? a0_q : uds_n;

  AST_A0_HELD: assert property (@(posedge clk) disable iff (rst)
    (held_q && any_strobe) |=> $stable(a0_q)); // R2

endmodule

// File: rtl/lane_host_path.sv
module lane_host_path
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 8,
  parameter int LANES    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         active,
  input  dir_e                         dir,
  input  logic [ADDR_W-2:0]            haddr,
  input  logic [NARROW_W*LANES-1:0]    hwdata,
  input  logic                         a0,
  input  logic [NARROW_W-1:0]          prdata,
  output logic [ADDR_W-1:0]            p_addr,
  output logic [NARROW_W-1:0]          p_wdata,
  output logic                         p_wdata_oe,
  output logic                         p_rd_n,
  output logic                         p_wr_n,
  output logic [NARROW_W*LANES-1:0]    h_rdata,
  output logic                         h_rdata_oe
);

  localparam int WIDE_W = NARROW_W * LANES;

  logic [WIDE_W-1:0]   rd_dup;
  logic [NARROW_W-1:0] wr_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_dup
    assign rd_dup[g*NARROW_W +: NARROW_W] = prdata;
  end

  // a0 = 0 selects the upper lane, a0 = 1 the lower lane
  assign wr_lane = a0 ? hwdata[NARROW_W-1:0] : hwdata[WIDE_W-1 -: NARROW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      p_addr     <= '0;
      p_wdata    <= '0;
      p_wdata_oe <= 1'b0;
      p_rd_n     <= 1'b1;
      p_wr_n     <= 1'b1;
      h_rdata    <= '0;
      h_rdata_oe <= 1'b0;
    end else begin
      p_addr     <= '0;
      p_wdata    <= '0;
      p_wdata_oe <= 1'b0;
      p_rd_n     <= 1'b1;
      p_wr_n     <= 1'b1;
      h_rdata    <= '0;
      h_rdata_oe <= 1'b0;
      if (active && dir == DIR_W2N) begin
        p_addr     <= {haddr, a0};
        p_wdata    <= wr_lane;
        p_wdata_oe <= 1'b1;
        p_wr_n     <= 1'b0;
      end else if (active && dir == DIR_N2W) begin
        p_addr     <= {haddr, a0};
        p_rd_n     <= 1'b0;
        h_rdata    <= rd_dup;
        h_rdata_oe <= 1'b1;
      end
    end
  end

  AST_PADDR_HI: assert property (@(posedge clk) disable iff (rst)
    (!p_wr_n || !p_rd_n) |-> p_addr[ADDR_W-1:1] == $past(haddr)); // R1

  AST_EVEN_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!p_wr_n && !p_addr[0]) |-> p_wdata == $past(hwdata[WIDE_W-1 -: NARROW_W])); // R4

  AST_ODD_LOWER: assert property (@(posedge clk) disable iff (rst)
    (!p_wr_n && p_addr[0]) |-> p_wdata == $past(hwdata[NARROW_W-1:0])); // R3

  AST_RD_DUP: assert property (@(posedge clk) disable iff (rst)
    h_rdata_oe |-> h_rdata[WIDE_W-1 -: NARROW_W] == h_rdata[NARROW_W-1:0]); // R5

endmodule

// File: rtl/lane_master_path.sv
module lane_master_path
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 8,
  parameter int LANES    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         active,
  input  dir_e                         dir,
  input  logic [ADDR_W-1:0]            maddr,
  input  logic [NARROW_W-1:0]          mwdata,
  input  logic [NARROW_W*LANES-1:0]    wrdata,
  output logic [ADDR_W-2:0]            w_addr,
  output logic [NARROW_W*LANES-1:0]    w_wdata,
  output logic                         w_wdata_oe,
  output logic                         w_rd_n,
  output logic                         w_uwr_n,
  output logic                         w_lwr_n,
  output logic [NARROW_W-1:0]          m_rdata,
  output logic                         m_rdata_oe
);

  localparam int WIDE_W = NARROW_W * LANES;

  logic [WIDE_W-1:0]   wr_dup;
  logic [NARROW_W-1:0] rd_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_dup
    assign wr_dup[g*NARROW_W +: NARROW_W] = mwdata;
  end

  assign rd_lane = maddr[0] ? wrdata[NARROW_W-1:0] : wrdata[WIDE_W-1 -: NARROW_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      w_addr     <= '0;
      w_wdata    <= '0;
      w_wdata_oe <= 1'b0;
      w_rd_n     <= 1'b1;
      w_uwr_n    <= 1'b1;
      w_lwr_n    <= 1'b1;
      m_rdata    <= '0;
      m_rdata_oe <= 1'b0;
    end else begin
      w_addr     <= '0;
      w_wdata    <= '0;
      w_wdata_oe <= 1'b0;
      w_rd_n     <= 1'b1;
      w_uwr_n    <= 1'b1;
      w_lwr_n    <= 1'b1;
      m_rdata    <= '0;
      m_rdata_oe <= 1'b0;
      if (active && dir == DIR_N2W) begin
        w_addr     <= maddr[ADDR_W-1:1];
        w_wdata    <= wr_dup;
        w_wdata_oe <= 1'b1;
        w_uwr_n    <= maddr[0];
        w_lwr_n    <= !maddr[0];
      end else if (active && dir == DIR_W2N) begin
        w_addr     <= maddr[ADDR_W-1:1];
        w_rd_n     <= 1'b0;
        m_rdata    <= rd_lane;
        m_rdata_oe <= 1'b1;
      end
    end
  end

  AST_UPPER_STROBE_EVEN: assert property (@(posedge clk) disable iff (rst)
    !w_uwr_n |-> (!$past(maddr[0]) && w_lwr_n)); // R7

  AST_LOWER_STROBE_ODD: assert property (@(posedge clk) disable iff (rst)
    !w_lwr_n |-> ($past(maddr[0]) && w_uwr_n)); // R7

  AST_MRD_LOWER: assert property (@(posedge clk) disable iff (rst)
    (m_rdata_oe && $past(maddr[0])) |-> m_rdata == $past(wrdata[NARROW_W-1:0])); // R6

  AST_MRD_UPPER: assert property (@(posedge clk) disable iff (rst)
    (m_rdata_oe && !$past(maddr[0])) |-> m_rdata == $past(wrdata[WIDE_W-1 -: NARROW_W])); // R6

endmodule

// File: rtl/lane_bridge.sv
module lane_bridge
  import lane_bridge_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_owner,
  input  logic                    dir_n2w,
  input  logic                    dir_w2n,
  input  logic [ADDR_W-2:0]       h_addr,
  input  logic [2*NARROW_W-1:0]   h_wdata,
  input  logic                    h_uds_n,
  input  logic                    h_lds_n,
  output logic [2*NARROW_W-1:0]   h_rdata,
  output logic                    h_rdata_oe,
  output logic [ADDR_W-1:0]       p_addr,
  output logic [NARROW_W-1:0]     p_wdata,
  output logic                    p_wdata_oe,
  input  logic [NARROW_W-1:0]     p_rdata,
  output logic                    p_rd_n,
  output logic                    p_wr_n,
  input  logic                    m_sel,
  input  logic [ADDR_W-1:0]       m_addr,
  input  logic [NARROW_W-1:0]     m_wdata,
  output logic [NARROW_W-1:0]     m_rdata,
  output logic                    m_rdata_oe,
  output logic [ADDR_W-2:0]       w_addr,
  output logic [2*NARROW_W-1:0]   w_wdata,
  output logic                    w_wdata_oe,
  input  logic [2*NARROW_W-1:0]   w_rdata,
  output logic                    w_rd_n,
  output logic                    w_uwr_n,
  output logic                    w_lwr_n,
  output logic                    dir_err
);

  localparam int LANES = 2;

  dir_e dir;
  logic a0_eff;
  logic host_act;
  logic mst_act;

  assign dir      = dir_decode(dir_n2w, dir_w2n);
  assign host_act = host_owner && !(h_uds_n && h_lds_n);
  assign mst_act  = !host_owner && m_sel;

  lane_a0_track u_a0 (
    .clk    (clk),
    .rst    (rst),
    .uds_n  (h_uds_n),
    .lds_n  (h_lds_n),
    .a0_eff (a0_eff)
  );

  lane_host_path #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .LANES    (LANES)
  ) u_host (
    .clk        (clk),
    .rst        (rst),
    .active     (host_act),
    .dir        (dir),
    .haddr      (h_addr),
    .hwdata     (h_wdata),
    .a0         (a0_eff),
    .prdata     (p_rdata),
    .p_addr     (p_addr),
    .p_wdata    (p_wdata),
    .p_wdata_oe (p_wdata_oe),
    .p_rd_n     (p_rd_n),
    .p_wr_n     (p_wr_n),
    .h_rdata    (h_rdata),
    .h_rdata_oe (h_rdata_oe)
  );

  lane_master_path #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .LANES    (LANES)
  ) u_mst (
    .clk        (clk),
    .rst        (rst),
    .active     (mst_act),
    .dir        (dir),
    .maddr      (m_addr),
    .mwdata     (m_wdata),
    .wrdata     (w_rdata),
    .w_addr     (w_addr),
    .w_wdata    (w_wdata),
    .w_wdata_oe (w_wdata_oe),
    .w_rd_n     (w_rd_n),
    .w_uwr_n    (w_uwr_n),
    .w_lwr_n    (w_lwr_n),
    .m_rdata    (m_rdata),
    .m_rdata_oe (m_rdata_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) dir_err <= 1'b0;
    else     dir_err <= (dir == DIR_CLASH);
  end

  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    dir_err |-> !(p_wdata_oe || h_rdata_oe || w_wdata_oe || m_rdata_oe)); // R9

  AST_CLASH_STROBES: assert property (@(posedge clk) disable iff (rst)
    dir_err |-> (p_rd_n && p_wr_n && w_rd_n && w_uwr_n && w_lwr_n)); // R9

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    (p_wdata_oe || h_rdata_oe) |-> !(w_wdata_oe || m_rdata_oe)); // R8

  AST_HOST_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    (!p_wr_n || !p_rd_n) |-> ($past(dir_n2w) != $past(dir_w2n))); // R10

endmodule

// File: tb/lane_bridge_test.sv
`timescale 1ns/1ps
module lane_bridge_test;

  typedef struct packed {
    logic        own, n2w, w2n, uds_n, lds_n;
    logic [6:0]  haddr;
    logic [15:0] hwd;
    logic [7:0]  prd;
    logic        msel;
    logic [7:0]  maddr;
    logic [7:0]  mwd;
    logic [15:0] wrd;
    logic [72:0] exp;
  } vec_t;

  // ctl order: p_wdata_oe p_rd_n p_wr_n h_rdata_oe w_wdata_oe w_rd_n w_uwr_n w_lwr_n m_rdata_oe dir_err
  localparam logic [9:0] C_IDLE = 10'b0110011100;
  localparam logic [9:0] C_PWR  = 10'b1100011100;
  localparam logic [9:0] C_PRD  = 10'b0011011100;
  localparam logic [9:0] C_MRD  = 10'b0110001110;
  localparam logic [9:0] C_MWU  = 10'b0110110100;
  localparam logic [9:0] C_MWL  = 10'b0110111000;
  localparam logic [9:0] C_ERR  = 10'b0110011101;

  function automatic vec_t mk(
    input logic own, input logic n2w, input logic w2n, input logic un, input logic ln,
    input logic [6:0] ha, input logic [15:0] hw, input logic [7:0] pr,
    input logic ms, input logic [7:0] ma, input logic [7:0] mw, input logic [15:0] wr,
    input logic [7:0] e_pa, input logic [7:0] e_pw, input logic [15:0] e_hr,
    input logic [6:0] e_wa, input logic [15:0] e_ww, input logic [7:0] e_mr,
    input logic [9:0] e_ctl);
    vec_t v;
    v.own = own; v.n2w = n2w; v.w2n = w2n; v.uds_n = un; v.lds_n = ln;
    v.haddr = ha; v.hwd = hw; v.prd = pr; v.msel = ms; v.maddr = ma;
    v.mwd = mw; v.wrd = wr;
    v.exp = {e_pa, e_pw, e_hr, e_wa, e_ww, e_mr, e_ctl};
    return v;
  endfunction

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    mk(1,0,1,0,1,7'h12,16'hA55A,8'h00,0,8'h00,8'h00,16'h0000, 8'h24,8'hA5,16'h0,7'h0,16'h0,8'h0,C_PWR), // R1 R3
    mk(1,0,1,1,0,7'h12,16'hA55A,8'h00,0,8'h00,8'h00,16'h0000, 8'h25,8'h5A,16'h0,7'h0,16'h0,8'h0,C_PWR), // R3
    mk(1,0,1,0,0,7'h7F,16'h1234,8'h00,0,8'h00,8'h00,16'h0000, 8'hFE,8'h12,16'h0,7'h0,16'h0,8'h0,C_PWR), // R4
    mk(1,1,0,0,1,7'h01,16'h0000,8'hC3,0,8'h00,8'h00,16'h0000, 8'h02,8'h00,16'hC3C3,7'h0,16'h0,8'h0,C_PRD), // R5
    mk(1,1,0,0,0,7'h40,16'hFFFF,8'h96,0,8'h00,8'h00,16'h0000, 8'h80,8'h00,16'h9696,7'h0,16'h0,8'h0,C_PRD), // R5
    mk(1,1,0,1,0,7'h40,16'h0000,8'h5B,0,8'h00,8'h00,16'h0000, 8'h81,8'h00,16'h5B5B,7'h0,16'h0,8'h0,C_PRD), // R5
    mk(0,0,1,1,1,7'h00,16'h0000,8'h00,1,8'h34,8'h00,16'hBEEF, 8'h00,8'h00,16'h0,7'h1A,16'h0,8'hBE,C_MRD), // R6
    mk(0,0,1,1,1,7'h00,16'h0000,8'h00,1,8'h35,8'h00,16'hBEEF, 8'h00,8'h00,16'h0,7'h1A,16'h0,8'hEF,C_MRD), // R6
    mk(0,1,0,1,1,7'h00,16'h0000,8'h00,1,8'hC8,8'h7E,16'h0000, 8'h00,8'h00,16'h0,7'h64,16'h7E7E,8'h0,C_MWU), // R7
    mk(0,1,0,1,1,7'h00,16'h0000,8'h00,1,8'hC9,8'h7E,16'h0000, 8'h00,8'h00,16'h0,7'h64,16'h7E7E,8'h0,C_MWL), // R7
    mk(1,0,0,0,0,7'h33,16'hFFFF,8'hFF,0,8'h00,8'h00,16'h0000, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_IDLE), // R8
    mk(0,0,1,1,1,7'h00,16'h0000,8'h00,0,8'h11,8'h00,16'hFFFF, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_IDLE), // R8
    mk(1,0,1,1,1,7'h00,16'h0000,8'h00,1,8'h44,8'h55,16'h6666, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_IDLE), // R8
    mk(0,0,1,0,0,7'h10,16'hABCD,8'h00,0,8'h00,8'h00,16'h0000, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_IDLE), // R8
    mk(1,1,1,0,0,7'h22,16'h1111,8'h22,0,8'h00,8'h00,16'h0000, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_ERR),  // R9
    mk(0,1,1,1,1,7'h00,16'h0000,8'h00,1,8'h44,8'h55,16'h6666, 8'h00,8'h00,16'h0,7'h0,16'h0,8'h0,C_ERR)   // R9
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R1+R3"; 1: return "R3"; 2: return "R4";
      3, 4, 5: return "R5"; 6, 7: return "R6"; 8, 9: return "R7";
      10, 11, 12, 13: return "R8";
      default: return "R9";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_owner = 0, dir_n2w = 0, dir_w2n = 0, h_uds_n = 1, h_lds_n = 1, m_sel = 0;
  logic [6:0]  h_addr = '0;
  logic [15:0] h_wdata = '0, w_rdata = '0;
  logic [7:0]  p_rdata = '0, m_addr = '0, m_wdata = '0;
  logic [15:0] h_rdata, w_wdata;
  logic [7:0]  p_addr, p_wdata, m_rdata;
  logic [6:0]  w_addr;
  logic h_rdata_oe, p_wdata_oe, p_rd_n, p_wr_n, m_rdata_oe, w_wdata_oe, w_rd_n, w_uwr_n, w_lwr_n, dir_err;

  always #2.5 clk = ~clk;

  lane_bridge uut (
    .clk(clk), .rst(rst), .host_owner(host_owner), .dir_n2w(dir_n2w), .dir_w2n(dir_w2n),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_uds_n(h_uds_n), .h_lds_n(h_lds_n),
    .h_rdata(h_rdata), .h_rdata_oe(h_rdata_oe), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_wdata_oe(p_wdata_oe), .p_rdata(p_rdata), .p_rd_n(p_rd_n), .p_wr_n(p_wr_n),
    .m_sel(m_sel), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_rdata_oe(m_rdata_oe), .w_addr(w_addr), .w_wdata(w_wdata), .w_wdata_oe(w_wdata_oe),
    .w_rdata(w_rdata), .w_rd_n(w_rd_n), .w_uwr_n(w_uwr_n), .w_lwr_n(w_lwr_n),
    .dir_err(dir_err)
  );

  logic [72:0] obs;
  assign obs = {p_addr, p_wdata, h_rdata, w_addr, w_wdata, m_rdata,
                p_wdata_oe, p_rd_n, p_wr_n, h_rdata_oe, w_wdata_oe, w_rd_n,
                w_uwr_n, w_lwr_n, m_rdata_oe, dir_err};

  localparam logic [72:0] IDLE_EXP = {63'd0, C_IDLE};

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [72:0] got, input logic [72:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, want);
    end
  endtask

  task automatic apply(input vec_t v);
    host_owner = v.own; dir_n2w = v.n2w; dir_w2n = v.w2n;
    h_uds_n = v.uds_n; h_lds_n = v.lds_n; h_addr = v.haddr; h_wdata = v.hwd;
    p_rdata = v.prd; m_sel = v.msel; m_addr = v.maddr; m_wdata = v.mwd; w_rdata = v.wrd;
  endtask

  task automatic go_idle();
    host_owner = 0; dir_n2w = 0; dir_w2n = 0; h_uds_n = 1; h_lds_n = 1; m_sel = 0;
    h_addr = '0; h_wdata = '0; p_rdata = '0; m_addr = '0; m_wdata = '0; w_rdata = '0;
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle(); cycle();
    check("R11 reset state", obs, IDLE_EXP);
    // R11: reset wins over an active host write
    apply(TBL[0]);
    cycle();
    check("R11 reset during cycle", obs, IDLE_EXP);
    go_idle();
    rst = 1'b0;
    cycle();

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      cycle();
      check(tag_of(i), obs, TBL[i].exp);
      go_idle();
      cycle();
      check("R8 idle after vector", obs, IDLE_EXP);
    end

    // R10: no output moves before the next clock edge
    apply(TBL[2]);
    #1;
    check("R10 before edge", obs, IDLE_EXP);
    @(negedge clk);
    check("R10 after edge", obs, TBL[2].exp);
    go_idle();
    cycle();

    // R2: lower-only cycle captures bit0 = 1, then upper drops while held
    host_owner = 1; dir_w2n = 1; h_addr = 7'h05; h_wdata = 16'hA1B2;
    h_uds_n = 1; h_lds_n = 0;
    cycle();
    check("R2 capture odd", {p_addr, p_wdata, p_wr_n}, {8'h0B, 8'hB2, 1'b0});
    h_uds_n = 0;
    cycle();
    check("R2 hold odd", {p_addr, p_wdata, p_wr_n}, {8'h0B, 8'hB2, 1'b0});
    h_uds_n = 1; h_lds_n = 1;
    cycle();
    check("R2 release", obs, IDLE_EXP);
    h_uds_n = 0; h_lds_n = 0;
    cycle();
    check("R2 recapture even", {p_addr, p_wdata, p_wr_n}, {8'h0A, 8'hA1, 1'b0});
    go_idle();
    cycle();

    done = 1;
    summary();
    $finish;
  end

endmodule